// File: doc/BRIEF.md
# Receive Frame Delay Buffer

This block sits between a line-side receive framer and a local serial (PCM) output. Payload bits arrive one per bit clock when a valid strobe is high. They are written into a small bit store and read back in the order they arrived. The local output frame is launched a programmable number of bit periods after each incoming frame marker.

The 10-bit water-level input sets that offset. A setting of N gives a delay of N+1 bit periods, so the usable range is 1 to 1024. Reading starts on the first outgoing frame start after reset. From then on, one bit is taken per clock whenever the store holds data. Each new incoming marker reloads the offset, so the outgoing frame tracks the incoming one at every 6 ms frame.

A separate monitor compares the number of bits held with a fixed ceiling of 185. When occupancy goes past that ceiling, it raises a sticky overflow flag. The ceiling is independent of the physical depth of 256 bits.

Top module: `rxdly_buf`

## Requirements
- R1: After an incoming frame marker is sampled at clock edge k with water level N, the outgoing frame-start output is high for the cycle that follows edge k+N+1.
- R2: A water level of 0 gives a one-cycle offset, and the maximum of 1023 gives 1024 cycles.
- R3: The outgoing frame start is a single-cycle pulse, produced once per marker whose count runs to completion.
- R4: A marker that arrives while a count is running restarts the count from that marker with the current water level. A marker sampled on the same edge as an expiry cancels that pulse.
- R5: The output bit is 0 until the first outgoing frame start. The first bit written after reset appears on the output in the same cycle as that pulse, and later bits follow in write order, one per clock.
- R6: With occupancy defined as bits written minus bits read, the overflow flag rises on the edge after occupancy reaches 186. With continuous valid input, a water level of 185 or more overflows and a level of 184 does not.
- R7: The overflow flag stays set until reset or an overflow-clear strobe. A clear takes effect only on an edge where occupancy is 185 or less.
- R8: During and right after reset, the frame-start output, the output bit and the overflow flag are all 0.
- R9: Once reading has started, the output bit is 0 in every cycle in which the store was empty. Writes are dropped while 256 bits are held.
- R10: A data bit offered while the valid strobe is low is not stored and never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | 1 | Serial payload bit |
| in_vld | input | 1 | Payload bit valid strobe |
| in_fs | input | 1 | Incoming frame-start marker, one cycle |
| wl_set | input | 10 | Water level; offset is value plus one bit period |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| out_bit | output | 1 | Delayed serial payload bit |
| out_fs | output | 1 | Outgoing frame-start pulse |
| ovf | output | 1 | Sticky occupancy overflow flag |

## Verification
The offset is exercised with several water levels: 0, 1, a small value, a mid value, both sides of the overflow ceiling (184 and 185), and a value beyond the physical depth, including 1023.

Each level is paired with its own bit pattern. The pattern data distinguishes a correct launch offset from a read order or read alignment that is off by a bit. The paired levels 184 and 185 separate a correct ceiling from an off-by-one comparison.

Marker patterns with a second marker mid-count, and with a second marker landing on the expiry edge, show whether the count restarts or runs on. A valid strobe toggled against an inverted data pattern shows whether invalid bits are dropped.

// File: rtl/rxdly_pkg.sv
package rxdly_pkg;
    localparam int WL_W_DEF      = 10;
    localparam int DEPTH_DEF     = 256;
    localparam int OVF_LIMIT_DEF = 185;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/rxdly_delay_ctr.sv
module rxdly_delay_ctr #(
    parameter int WL_W = rxdly_pkg::WL_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mark,
    input  logic [WL_W-1:0] wl,
    output logic            fire,
    output logic            started,
    output logic            fs_out
);
    typedef struct packed {
        logic [WL_W-1:0]        cnt;
        rxdly_pkg::cnt_state_e  st;
        logic                   started;
        logic                   fs;
    } ctr_t;

    ctr_t s_d, s_q;
    logic fire_c;

    always_comb begin
        s_d    = s_q;
        s_d.fs = 1'b0;
        fire_c = 1'b0;
        if (mark) begin
            // a fresh marker always restarts the offset count
            s_d.st  = rxdly_pkg::CNT_RUN;
            s_d.cnt = wl;
        end else if (s_q.st == rxdly_pkg::CNT_RUN) begin
            if (s_q.cnt == '0) begin
                fire_c      = 1'b1;
                s_d.st      = rxdly_pkg::CNT_IDLE;
                s_d.fs      = 1'b1;
                s_d.started = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, st: rxdly_pkg::CNT_IDLE, started: 1'b0, fs: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign fire    = fire_c;
    assign started = s_q.started;
    assign fs_out  = s_q.fs;
endmodule

// File: rtl/rxdly_bitmem.sv
module rxdly_bitmem #(
    parameter int DEPTH = rxdly_pkg::DEPTH_DEF,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_bit,
    input  logic        rd_en,
    output logic [AW:0] wptr,
    output logic [AW:0] rptr,
    output logic        dout
);
    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
        logic        dout;
    } mem_st_t;

    mem_st_t s_d, s_q;
    logic    mem_q [DEPTH];

    always_comb begin
        s_d      = s_q;
        s_d.dout = 1'b0;
        if (wr_en) begin
            s_d.wp = s_q.wp + 1'b1;
        end
        if (rd_en) begin
            s_d.dout = mem_q[s_q.rp[AW-1:0]];
            s_d.rp   = s_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[s_q.wp[AW-1:0]] <= wr_bit;
        end
    end

    assign wptr = s_q.wp;
    assign rptr = s_q.rp;
    assign dout = s_q.dout;
endmodule

// File: rtl/rxdly_occ_mon.sv
module rxdly_occ_mon #(
    parameter int AW        = 8,
    parameter int OVF_LIMIT = rxdly_pkg::OVF_LIMIT_DEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] wptr,
    input  logic [AW:0] rptr,
    input  logic        clr,
    output logic [AW:0] occ,
    output logic        full,
    output logic        ovf
);
    localparam logic [AW:0] LIM_V  = (AW+1)'(OVF_LIMIT);
    localparam logic [AW:0] FULL_V = (AW+1)'(1 << AW);

    typedef struct packed {
        logic flag;
    } mon_t;

    mon_t        s_d, s_q;
    logic [AW:0] occ_c;

    always_comb begin
        occ_c = wptr - rptr;
        s_d   = s_q;
        if (occ_c > LIM_V) begin
            s_d.flag = 1'b1;
        end else if (clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign occ  = occ_c;
    assign full = (occ_c == FULL_V);
    assign ovf  = s_q.flag;
endmodule

// File: rtl/rxdly_buf.sv
module rxdly_buf #(
    parameter int WL_W      = rxdly_pkg::WL_W_DEF,
    parameter int DEPTH     = rxdly_pkg::DEPTH_DEF,
    parameter int OVF_LIMIT = rxdly_pkg::OVF_LIMIT_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_bit,
    input  logic            in_vld,
    input  logic            in_fs,
    input  logic [WL_W-1:0] wl_set,
    input  logic            ovf_clr,
    output logic            out_bit,
    output logic            out_fs,
    output logic            ovf
);
    localparam int AW = $clog2(DEPTH);

    logic        fire;
    logic        started;
    logic        full;
    logic        wr_en;
    logic        rd_en;
    logic [AW:0] wptr;
    logic [AW:0] rptr;
    logic [AW:0] occ;

    assign wr_en = in_vld & ~full;
    assign rd_en = (fire | started) & (occ != '0);

    rxdly_delay_ctr #(.WL_W(WL_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mark    (in_fs),
        .wl      (wl_set),
        .fire    (fire),
        .started (started),
        .fs_out  (out_fs)
    );

    rxdly_bitmem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_bit (in_bit),
        .rd_en  (rd_en),
        .wptr   (wptr),
        .rptr   (rptr),
        .dout   (out_bit)
    );

    rxdly_occ_mon #(.AW(AW), .OVF_LIMIT(OVF_LIMIT)) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .wptr  (wptr),
        .rptr  (rptr),
        .clr   (ovf_clr),
        .occ   (occ),
        .full  (full),
        .ovf   (ovf)
    );
endmodule

// File: rtl/rxdly_buf_chk.sv
module rxdly_buf_chk #(
    parameter int WL_W      = 10,
    parameter int AW        = 8,
    parameter int OVF_LIMIT = 185
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_fs,
    input logic [WL_W-1:0] wl_set,
    input logic            ovf_clr,
    input logic            out_fs,
    input logic            out_bit,
    input logic            ovf,
    input logic [AW:0]     occ,
    input logic            started
);
    localparam logic [AW:0]     LIM_V   = (AW+1)'(OVF_LIMIT);
    localparam logic [AW:0]     FULL_V  = (AW+1)'(1 << AW);
    localparam logic [WL_W+1:0] GAP_MAX = '1;

    logic [WL_W+1:0] gap_q;
    logic [WL_W-1:0] wlcap_q;
    logic            seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            wlcap_q <= '0;
            seen_q  <= 1'b0;
        end else if (in_fs) begin
            gap_q   <= '0;
            wlcap_q <= wl_set;
            seen_q  <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_launch_offset: assert property (@(posedge clk) disable iff (!rst_n)
        out_fs |-> (seen_q && gap_q == ({2'b00, wlcap_q} + (WL_W+2)'(1))));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_fs |=> !out_fs);

    a_r4_marker_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        in_fs |=> !out_fs);

    a_r5_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> !out_bit);

    a_r6_ceiling_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (occ > LIM_V) |=> ovf);

    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && occ <= LIM_V) |=> !ovf);

    a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_V);
endmodule

bind rxdly_buf rxdly_buf_chk #(.WL_W(WL_W), .AW(AW), .OVF_LIMIT(OVF_LIMIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_fs   (in_fs),
    .wl_set  (wl_set),
    .ovf_clr (ovf_clr),
    .out_fs  (out_fs),
    .out_bit (out_bit),
    .ovf     (ovf),
    .occ     (occ),
    .started (started)
);

// File: tb/rxdly_buf_test.sv
`timescale 1ns/1ps
module rxdly_buf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_vld = 1'b0;
    logic       in_fs = 1'b0;
    logic [9:0] wl_set = '0;
    logic       ovf_clr = 1'b0;
    logic       out_bit;
    logic       out_fs;
    logic       ovf;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    rxdly_buf uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bit  (in_bit),
        .in_vld  (in_vld),
        .in_fs   (in_fs),
        .wl_set  (wl_set),
        .ovf_clr (ovf_clr),
        .out_bit (out_bit),
        .out_fs  (out_fs),
        .ovf     (ovf)
    );

    // water level (10 bits) and data pattern (32 bits)
    localparam logic [41:0] VECS [0:7] = '{
        {10'd0,    32'hA5C3_1E77},
        {10'd1,    32'h3C96_0FF1},
        {10'd7,    32'hDEAD_BEEF},
        {10'd40,   32'h1234_5678},
        {10'd184,  32'h9E37_79B9},
        {10'd185,  32'h7F4A_7C15},
        {10'd300,  32'hC0FF_EE11},
        {10'd1023, 32'h5555_AAAA}
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_fs = 1'b0; in_vld = 1'b0; in_bit = 1'b0; ovf_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R8", "out_fs in reset", out_fs, 1'b0);
        check("R8", "out_bit in reset", out_bit, 1'b0);
        check("R8", "ovf in reset", ovf, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vector(input logic [9:0] wl, input logic [31:0] pat);
        int d = int'(wl) + 1;
        int n = d + 40;
        do_reset();
        wl_set = wl;
        for (int i = 0; i < n; i++) begin
            if (i != 0) @(negedge clk);
            in_fs  = (i == 0);
            in_vld = 1'b1;
            in_bit = pat[i % 32];
            @(posedge clk);
            #1;
            // R1 R2 R3: pulse exactly at offset wl+1
            check("R1", "out_fs timing", out_fs, (i == d));
            // R5: quiet before launch, then write order
            if (i < d) check("R5", "out_bit before launch", out_bit, 1'b0);
            else       check("R5", "out_bit order", out_bit, pat[(i - d) % 32]);
            // R6: flag one edge after occupancy reaches 186
            check("R6", "ovf level", ovf, (d >= 186) && (i >= 186));
        end
        @(negedge clk);
        in_fs = 1'b0; in_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // table walk: R1 R2 R3 R5 R6 R9 (wl 1023 fills the store)
        for (int v = 0; v < 8; v++) begin
            run_vector(VECS[v][41:32], VECS[v][31:0]);
        end

        // R4: second marker mid-count restarts from it
        do_reset();
        wl_set = 10'd10;
        for (int i = 0; i < 25; i++) begin
            if (i != 0) @(negedge clk);
            in_fs = (i == 0) || (i == 5);
            in_vld = 1'b1; in_bit = 1'b0;
            @(posedge clk); #1;
            check("R4", "restart pulse", out_fs, (i == 16));
        end

        // R4: marker on the expiry edge cancels that pulse
        do_reset();
        wl_set = 10'd3;
        for (int i = 0; i < 12; i++) begin
            if (i != 0) @(negedge clk);
            in_fs = (i == 0) || (i == 4);
            in_vld = 1'b1; in_bit = 1'b0;
            @(posedge clk); #1;
            check("R4", "cancel on expiry", out_fs, (i == 8));
        end

        // R10 and R9: invalid bits (driven 1) dropped; empty reads give 0
        do_reset();
        wl_set = 10'd5;
        for (int i = 0; i < 30; i++) begin
            if (i != 0) @(negedge clk);
            in_fs  = (i == 0);
            in_vld = (i % 2 == 0);
            in_bit = (i % 2 != 0);
            @(posedge clk); #1;
            check("R10", "invalid bit blocked", out_bit, 1'b0);
            check("R1", "out_fs with gaps", out_fs, (i == 6));
        end

        // R7: clear ignored while over ceiling; sticky after draining; clear works
        do_reset();
        wl_set = 10'd200;
        for (int i = 0; i < 200; i++) begin
            if (i != 0) @(negedge clk);
            in_fs   = (i == 0);
            in_vld  = 1'b1;
            in_bit  = 1'b1;
            ovf_clr = (i == 195);
            @(posedge clk); #1;
            if (i == 195) check("R7", "clear while over ceiling", ovf, 1'b1);
        end
        @(negedge clk);
        in_fs = 1'b0; in_vld = 1'b0; ovf_clr = 1'b0;
        repeat (300) @(posedge clk);
        #1;
        check("R7", "sticky after drain", ovf, 1'b1);
        check("R9", "empty output", out_bit, 1'b0);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(posedge clk); #1;
        check("R7", "cleared by strobe", ovf, 1'b0);
        @(negedge clk);
        ovf_clr = 1'b0;
        @(posedge clk); #1;
        check("R7", "stays clear", ovf, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule